// File: doc/BRIEF.md
# Atomic Store Attribute Checker

This block decides whether a conditional atomic store may go ahead on the page its address falls in. The caller gives it the result of address translation for the store: a fault code, the read and write permissions, and the page's cache attribute. It also gives a configuration bit that says whether a data cache is fitted, and a 6-bit atomic control word. The block answers with either a pass or an exception cause. When it raises an exception, it also returns the address that failed.

The control word holds three 2-bit policy fields. The page's cache attribute picks which field applies. A zero field means atomic stores are not allowed for that class of page. Translation faults and permission faults are checked first, and the attribute check only counts when both of those are clean. The decision logic is purely combinational and is followed by one register stage, so every request produces its answer one clock later.

Top module: `atomchk_top`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `respValid`, `respPass` and `respExc` are 0, and `respCause` and `respAddr` are 0.
- R2: Each cycle with `reqValid` high produces exactly one result, with `respValid` high on the following cycle. A cycle with `reqValid` low produces `respValid` low on the following cycle.
- R3: A nonzero `xlatFault` gives `respExc`=1 with `respCause` equal to that fault code and `respAddr` equal to the request address.
- R4: With `xlatFault`=0, if `permRead` or `permWrite` is 0 (or both are), the result is `respExc`=1 with cause `CAUSE_STORE_PROHIBIT` (default 29). The block never reports a load-prohibited cause.
- R5: When `dcachePresent`=0, the attribute is treated as bypass whatever `cacheAttr` says, including the isolate value.
- R6: The attribute is coded on 3 bits: 0 is bypass, 1 is write-through, 2 is write-back, 3 is isolate, and 4 to 7 are other. Bypass uses `atomCtl[1:0]`, write-through uses `atomCtl[3:2]` and write-back uses `atomCtl[5:4]`. A nonzero selected field gives `respPass`=1.
- R7: A selected field equal to 0 gives `respExc`=1 with cause `CAUSE_LS_ERROR` (default 3).
- R8: The isolate attribute (3), when a data cache is present and the permissions are clean, always gives cause `CAUSE_LS_ERROR`, whatever `atomCtl` holds.
- R9: Attributes 4 to 7, when a data cache is present, always pass, whatever `atomCtl` holds.
- R10: The checks have a fixed priority. A translation fault outranks a permission fault, and a permission fault outranks the attribute check.
- R11: When `respValid` is high, exactly one of `respPass` and `respExc` is high. A pass carries `respCause`=0 and `respAddr`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present this cycle |
| reqAddr | input | ADDR_W | Virtual address of the atomic store |
| xlatFault | input | CAUSE_W | Translation fault code; 0 means the translation succeeded |
| permRead | input | 1 | Page allows reads |
| permWrite | input | 1 | Page allows writes |
| cacheAttr | input | 3 | Cache attribute of the page |
| dcachePresent | input | 1 | A data cache is configured |
| atomCtl | input | 6 | Atomic control word: three 2-bit policy fields |
| respValid | output | 1 | A result is present this cycle |
| respPass | output | 1 | The store may proceed |
| respExc | output | 1 | The store raises an exception |
| respCause | output | CAUSE_W | Exception cause code |
| respAddr | output | ADDR_W | Faulting address |

## Verification
The assertions assume that every request input is a known value in any cycle where `reqValid` is high. They also assume that the two parameter cause codes are nonzero, so that a zero `respCause` can only mean a pass. The stimulus drives every request field with a defined value on each request cycle, and it parks the fields at zero in idle cycles. The only cause values it uses come from the parameters and from explicit nonzero fault codes. The stimulus walks all eight attribute codes with and without a data cache, against control words that zero each field in turn. It also combines faults with bad attributes so that the priority order is exercised.

// File: rtl/atomchk_pkg.sv
package atomchk_pkg;
  localparam int ATTR_W  = 3;
  localparam int FIELD_W = 2;
  localparam int N_FIELD = 3;
  localparam int CTL_W   = FIELD_W * N_FIELD;

  typedef logic [ATTR_W-1:0] attr_t;

  localparam attr_t ATTR_BYPASS  = 3'd0;
  localparam attr_t ATTR_WTHRU   = 3'd1;
  localparam attr_t ATTR_WBACK   = 3'd2;
  localparam attr_t ATTR_ISOLATE = 3'd3;

  // Strobes from the decision logic to the datapath.
  typedef struct packed {
    logic capture;
    logic pass;
    logic useFault;
    logic useStore;
    logic useLsErr;
  } ctlStrobe_t;
endpackage

// File: rtl/atomchk_ctrl.sv
module atomchk_ctrl
  import atomchk_pkg::*;
(
  input  logic       reqValid,
  input  logic       faultHit,
  input  logic       permOk,
  input  logic       isIsolate,
  input  logic       hasField,
  input  logic       fieldZero,
  output ctlStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.capture = reqValid;
    if (reqValid) begin
      // Fixed order: translation, then permission, then attribute policy.
      if (faultHit)                    strobe.useFault = 1'b1;
      else if (!permOk)                strobe.useStore = 1'b1;
      else if (isIsolate)              strobe.useLsErr = 1'b1;
      else if (hasField && fieldZero)  strobe.useLsErr = 1'b1;
      else                             strobe.pass     = 1'b1;
    end
  end
endmodule

// File: rtl/atomchk_dp.sv
module atomchk_dp
  import atomchk_pkg::*;
#(
  parameter int ADDR_W               = 32,
  parameter int CAUSE_W              = 6,
  parameter int CAUSE_STORE_PROHIBIT = 29,
  parameter int CAUSE_LS_ERROR       = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [CAUSE_W-1:0] xlatFault,
  input  logic               permRead,
  input  logic               permWrite,
  input  attr_t              cacheAttr,
  input  logic               dcachePresent,
  input  logic [CTL_W-1:0]   atomCtl,
  input  ctlStrobe_t         strobe,
  output logic               faultHit,
  output logic               permOk,
  output logic               isIsolate,
  output logic               hasField,
  output logic               fieldZero,
  output logic               respValid,
  output logic               respPass,
  output logic               respExc,
  output logic [CAUSE_W-1:0] respCause,
  output logic [ADDR_W-1:0]  respAddr
);
  localparam logic [CAUSE_W-1:0] STORE_CODE = CAUSE_W'(CAUSE_STORE_PROHIBIT);
  localparam logic [CAUSE_W-1:0] LSERR_CODE = CAUSE_W'(CAUSE_LS_ERROR);

  attr_t              effAttr;
  logic [N_FIELD-1:0] fieldEmpty;
  logic [CAUSE_W-1:0] nextCause;

  assign faultHit = |xlatFault;
  assign permOk   = permRead & permWrite;
  // Without a data cache every page behaves as bypass.
  assign effAttr  = dcachePresent ? cacheAttr : ATTR_BYPASS;
  assign isIsolate = (effAttr == ATTR_ISOLATE);
  assign hasField  = (effAttr < attr_t'(N_FIELD));

  for (genvar f = 0; f < N_FIELD; f++) begin : g_field
    assign fieldEmpty[f] = ~|atomCtl[f*FIELD_W +: FIELD_W];
  end

  always_comb begin
    fieldZero = 1'b0;
    for (int f = 0; f < N_FIELD; f++) begin
      if (effAttr == attr_t'(f)) fieldZero = fieldEmpty[f];
    end
  end

  always_comb begin
    nextCause = '0;
    if (strobe.useFault)      nextCause = xlatFault;
    else if (strobe.useStore) nextCause = STORE_CODE;
    else if (strobe.useLsErr) nextCause = LSERR_CODE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respPass  <= 1'b0;
      respExc   <= 1'b0;
      respCause <= '0;
      respAddr  <= '0;
    end else begin
      respValid <= strobe.capture;
      respPass  <= strobe.pass;
      respExc   <= strobe.useFault | strobe.useStore | strobe.useLsErr;
      respCause <= nextCause;
      respAddr  <= (strobe.capture && !strobe.pass) ? reqAddr : '0;
    end
  end
endmodule

// File: rtl/atomchk_top.sv
module atomchk_top
  import atomchk_pkg::*;
#(
  parameter int ADDR_W               = 32,
  parameter int CAUSE_W              = 6,
  parameter int CAUSE_STORE_PROHIBIT = 29,
  parameter int CAUSE_LS_ERROR       = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [CAUSE_W-1:0] xlatFault,
  input  logic               permRead,
  input  logic               permWrite,
  input  logic [2:0]         cacheAttr,
  input  logic               dcachePresent,
  input  logic [5:0]         atomCtl,
  output logic               respValid,
  output logic               respPass,
  output logic               respExc,
  output logic [CAUSE_W-1:0] respCause,
  output logic [ADDR_W-1:0]  respAddr
);
  ctlStrobe_t strobe;
  logic faultHit, permOk, isIsolate, hasField, fieldZero;

  atomchk_ctrl u_ctrl (
    .reqValid (reqValid),
    .faultHit (faultHit),
    .permOk   (permOk),
    .isIsolate(isIsolate),
    .hasField (hasField),
    .fieldZero(fieldZero),
    .strobe   (strobe)
  );

  atomchk_dp #(
    .ADDR_W              (ADDR_W),
    .CAUSE_W             (CAUSE_W),
    .CAUSE_STORE_PROHIBIT(CAUSE_STORE_PROHIBIT),
    .CAUSE_LS_ERROR      (CAUSE_LS_ERROR)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .reqAddr      (reqAddr),
    .xlatFault    (xlatFault),
    .permRead     (permRead),
    .permWrite    (permWrite),
    .cacheAttr    (cacheAttr),
    .dcachePresent(dcachePresent),
    .atomCtl      (atomCtl),
    .strobe       (strobe),
    .faultHit     (faultHit),
    .permOk       (permOk),
    .isIsolate    (isIsolate),
    .hasField     (hasField),
    .fieldZero    (fieldZero),
    .respValid    (respValid),
    .respPass     (respPass),
    .respExc      (respExc),
    .respCause    (respCause),
    .respAddr     (respAddr)
  );
endmodule

// File: rtl/atomchk_sva.sv
module atomchk_sva #(
  parameter int ADDR_W               = 32,
  parameter int CAUSE_W              = 6,
  parameter int CAUSE_STORE_PROHIBIT = 29,
  parameter int CAUSE_LS_ERROR       = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic [ADDR_W-1:0]  reqAddr,
  input logic [CAUSE_W-1:0] xlatFault,
  input logic               permRead,
  input logic               permWrite,
  input logic [2:0]         cacheAttr,
  input logic               dcachePresent,
  input logic               respValid,
  input logic               respPass,
  input logic               respExc,
  input logic [CAUSE_W-1:0] respCause,
  input logic [ADDR_W-1:0]  respAddr
);
  a_r2_req_gives_resp: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);
  a_r2_idle_gives_none: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $countones({respPass, respExc}) == 1);
  a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rstN)
    !respValid |-> !respPass && !respExc);
  a_r11_pass_clean: assert property (@(posedge clk) disable iff (!rstN)
    respPass |-> respCause == '0 && respAddr == '0);
  a_r3_fault_code: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault != '0) |=>
      respExc && respCause == $past(xlatFault) && respAddr == $past(reqAddr));
  a_r4_store_prohibit: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault == '0 && !(permRead && permWrite)) |=>
      respExc && respCause == CAUSE_W'(CAUSE_STORE_PROHIBIT));
  a_r8_isolate: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault == '0 && permRead && permWrite && dcachePresent
     && cacheAttr == 3'd3) |=> respExc && respCause == CAUSE_W'(CAUSE_LS_ERROR));
  a_r9_other_pass: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && xlatFault == '0 && permRead && permWrite && dcachePresent
     && cacheAttr[2]) |=> respPass);
endmodule

bind atomchk_top atomchk_sva #(
  .ADDR_W              (ADDR_W),
  .CAUSE_W             (CAUSE_W),
  .CAUSE_STORE_PROHIBIT(CAUSE_STORE_PROHIBIT),
  .CAUSE_LS_ERROR      (CAUSE_LS_ERROR)
) u_sva (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqAddr      (reqAddr),
  .xlatFault    (xlatFault),
  .permRead     (permRead),
  .permWrite    (permWrite),
  .cacheAttr    (cacheAttr),
  .dcachePresent(dcachePresent),
  .respValid    (respValid),
  .respPass     (respPass),
  .respExc      (respExc),
  .respCause    (respCause),
  .respAddr     (respAddr)
);

// File: tb/atomchk_top_tb.sv
module atomchk_top_tb;
  localparam int AW = 32;
  localparam int CW = 6;
  localparam logic [CW-1:0] C_STORE = 6'd29;
  localparam logic [CW-1:0] C_LSERR = 6'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [CW-1:0] xlatFault = '0;
  logic permRead = 1'b0, permWrite = 1'b0;
  logic [2:0] cacheAttr = '0;
  logic dcachePresent = 1'b0;
  logic [5:0] atomCtl = '0;
  logic respValid, respPass, respExc;
  logic [CW-1:0] respCause;
  logic [AW-1:0] respAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    logic          pass;
    logic [CW-1:0] cause;
    logic [AW-1:0] addr;
    string         req;
  } expItem_t;

  expItem_t expQ[$];

  always #10 clk = ~clk;

  atomchk_top u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .xlatFault(xlatFault), .permRead(permRead), .permWrite(permWrite),
    .cacheAttr(cacheAttr), .dcachePresent(dcachePresent), .atomCtl(atomCtl),
    .respValid(respValid), .respPass(respPass), .respExc(respExc),
    .respCause(respCause), .respAddr(respAddr)
  );

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model written from the requirement list.
  function automatic expItem_t model(input logic [AW-1:0] a, input logic [CW-1:0] f,
      input logic r, input logic w, input logic [2:0] at, input logic dc,
      input logic [5:0] ctl, input string req);
    expItem_t e;
    logic [2:0] eff;
    e.req = req; e.pass = 1'b0; e.addr = a; e.cause = '0;
    eff = dc ? at : 3'd0;                          // R5
    if (f != '0) e.cause = f;                       // R3, R10
    else if (!(r && w)) e.cause = C_STORE;          // R4
    else if (eff == 3'd3) e.cause = C_LSERR;        // R8
    else if (eff < 3'd3 && ctl[eff*2 +: 2] == 2'b00) e.cause = C_LSERR; // R6, R7
    else begin e.pass = 1'b1; e.addr = '0; end      // R9, R11
    return e;
  endfunction

  task automatic send(input logic [AW-1:0] a, input logic [CW-1:0] f,
      input logic r, input logic w, input logic [2:0] at, input logic dc,
      input logic [5:0] ctl, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; xlatFault = f; permRead = r; permWrite = w;
    cacheAttr = at; dcachePresent = dc; atomCtl = ctl;
    expQ.push_back(model(a, f, r, w, at, dc, ctl, req));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0; reqAddr = '0; xlatFault = '0; permRead = 1'b0;
      permWrite = 1'b0; cacheAttr = '0; dcachePresent = 1'b0; atomCtl = '0;
    end
  endtask

  // Monitor: pop and compare each result as it appears.
  always @(negedge clk) begin
    #1;
    if (rstN && respValid) begin
      if (expQ.size() == 0) begin
        check("R2", "unexpected result", 1, 0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(e.req, "pass", AW'(respPass), AW'(e.pass));
        check(e.req, "exc", AW'(respExc), AW'(!e.pass));
        check(e.req, "cause", AW'(respCause), AW'(e.cause));
        check(e.req, "addr", respAddr, e.addr);
      end
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "respValid", AW'(respValid), 0);
    check("R1", "respPass", AW'(respPass), 0);
    check("R1", "respExc", AW'(respExc), 0);
    check("R1", "respCause", AW'(respCause), 0);
    check("R1", "respAddr", respAddr, 0);
    rstN = 1'b1;

    // R3 / R10: translation fault reported verbatim, ahead of everything
    send(32'h1000_0040, 6'd5, 1, 1, 3'd0, 1, 6'h3f, "R3");
    send(32'h2000_0080, 6'd17, 0, 0, 3'd3, 1, 6'h00, "R10");
    // R4: each missing permission
    send(32'h3000_0000, 6'd0, 0, 1, 3'd4, 1, 6'h3f, "R4");
    send(32'h3000_0004, 6'd0, 1, 0, 3'd0, 1, 6'h3f, "R4");
    send(32'h3000_0008, 6'd0, 0, 0, 3'd1, 1, 6'h3f, "R4");
    send(32'h3000_000c, 6'd0, 1, 0, 3'd3, 1, 6'h3f, "R10");
    // R6: each field selects its own attribute
    send(32'h4000_0000, 6'd0, 1, 1, 3'd0, 1, 6'b000001, "R6");
    send(32'h4000_0010, 6'd0, 1, 1, 3'd1, 1, 6'b001000, "R6");
    send(32'h4000_0020, 6'd0, 1, 1, 3'd2, 1, 6'b110000, "R6");
    // R7: zero selected field, other fields full
    send(32'h5000_0000, 6'd0, 1, 1, 3'd0, 1, 6'b111100, "R7");
    send(32'h5000_0010, 6'd0, 1, 1, 3'd1, 1, 6'b110011, "R7");
    send(32'h5000_0020, 6'd0, 1, 1, 3'd2, 1, 6'b001111, "R7");
    // R5: no data cache forces bypass
    send(32'h6000_0000, 6'd0, 1, 1, 3'd2, 0, 6'b000010, "R5");
    send(32'h6000_0010, 6'd0, 1, 1, 3'd2, 0, 6'b110000, "R5");
    send(32'h6000_0020, 6'd0, 1, 1, 3'd3, 0, 6'b000001, "R5");
    // R8: isolate always errors; R9: others always pass
    send(32'h7000_0000, 6'd0, 1, 1, 3'd3, 1, 6'h3f, "R8");
    send(32'h7000_0010, 6'd0, 1, 1, 3'd5, 1, 6'h00, "R9");
    send(32'h7000_0020, 6'd0, 1, 1, 3'd7, 1, 6'h00, "R9");
    idle(3);
    // R2: no result appears while idle
    check("R2", "idle respValid", AW'(respValid), 0);

    // Sweep: all attributes, both cache settings, each field zeroed in turn (R11)
    for (int at = 0; at < 8; at++)
      for (int dc = 0; dc < 2; dc++)
        for (int k = 0; k < 4; k++)
          send(AW'(32'h8000_0000 + at*64 + dc*16 + k), 6'd0, 1, 1, 3'(at), dc[0],
               (k == 3) ? 6'h3f : (6'h3f & ~(6'b11 << (k*2))), "R11");
    idle(3);
    check("R2", "drained", AW'(expQ.size()), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R2 watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule